// File: doc/BRIEF.md
# Test Access Port Controller with Fixed Capture Word

This block is a serial test access port controller. A host drives three slow pins: a test clock, a mode select and serial data in. The block answers on a serial data out pin. Inside are the standard sixteen-state port controller, an instruction register and one data register. Every move of the controller, and the register action tied to the state it enters, happens on a rising edge of the test clock. That edge is found by sampling the pins with the fast system clock.

The data register has one purpose: whenever the controller enters its data capture state, the register loads the fixed word 0xDEADBEEF, whatever instruction is held. Both registers shift towards their least significant bit. The bit that falls out goes to the data out pin, and the new bit from the data in pin enters at the top. A host can therefore walk the controller, read back the fixed word, and read back any bits it shifted in by shifting for longer. The instruction register is not decoded.

Top module: `scan_tap`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in the reset state (code 0) and drives `scan_out_o` low. It also sets the instruction register to 1, so after reset the instruction register shifts out as 1 followed by zeros.
- R2: The controller and both registers change only on a rising edge of `scan_clk_i`. Activity on `scan_sel_i` or `scan_in_i` while the test clock is steady has no effect, and neither has a falling edge. Each rising edge acts once, SYNC_STAGES+1 system clocks after it appears at the pin.
- R3: The state codes on `tap_state_o` are: 0 reset, 1 idle, 2 DR-select, 3 DR-capture, 4 DR-shift, 5 DR-exit1, 6 DR-pause, 7 DR-exit2, 8 DR-update, 9 IR-select, 10 IR-capture, 11 IR-shift, 12 IR-exit1, 13 IR-pause, 14 IR-exit2, 15 IR-update. Every state follows the standard two-way successor on the `scan_sel_i` value sampled at the edge.
- R4: Five rising edges with `scan_sel_i` high reach the reset state (code 0) from any state.
- R5: Every edge that enters or stays in the reset state sets the instruction register to 1.
- R6: Every entry to DR-capture loads the data register with 0xDEADBEEF, replacing what was shifted in before.
- R7: Every edge that enters or stays in DR-shift moves the data register's bit 0 to `scan_out_o`, shifts the register right, and writes the sampled `scan_in_i` into bit DR_W-1. Bits shifted in therefore come out after DR_W further shifts, first bit first.
- R8: Every edge that enters or stays in IR-shift does the same with the IR_W-bit instruction register, writing `scan_in_i` into bit IR_W-1.
- R9: `scan_out_o` holds its value on every edge that does not enter a shift state. Both registers keep their contents through exit, pause, update and IR-capture, so a shift resumed through exit2 continues with the next bit.
- R10: The first bit of a shift appears on `scan_out_o` on the same edge that enters the shift state. For the data register this is bit 0 of the capture word, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the test pins |
| rst | input | 1 | Synchronous active-high reset |
| scan_clk_i | input | 1 | Test clock, slow and asynchronous to `clk` |
| scan_sel_i | input | 1 | Mode select that steers the controller |
| scan_in_i | input | 1 | Serial data into the active shift register |
| scan_out_o | output | 1 | Registered serial data out |
| tap_state_o | output | 4 | Present controller state, coded as in R3 |

## Verification
Bits shifted into the data register are the hardest thing to see from the pins, because every way back to capture overwrites them with the fixed word. The bench stays in DR-shift for twice the register length, so the first half of the data-in stream comes back out during the second half. A separate scenario breaks a shift with exit1, pause and exit2 to show that the shift resumes at the next bit. Instruction register contents are read back the same way, and their survival across IR-capture is shown by re-entering the shift state.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [3:0] {
        ST_RESET      = 4'd0,
        ST_IDLE       = 4'd1,
        ST_DR_SELECT  = 4'd2,
        ST_DR_CAPTURE = 4'd3,
        ST_DR_SHIFT   = 4'd4,
        ST_DR_EXIT1   = 4'd5,
        ST_DR_PAUSE   = 4'd6,
        ST_DR_EXIT2   = 4'd7,
        ST_DR_UPDATE  = 4'd8,
        ST_IR_SELECT  = 4'd9,
        ST_IR_CAPTURE = 4'd10,
        ST_IR_SHIFT   = 4'd11,
        ST_IR_EXIT1   = 4'd12,
        ST_IR_PAUSE   = 4'd13,
        ST_IR_EXIT2   = 4'd14,
        ST_IR_UPDATE  = 4'd15
    } tap_state_e;

    localparam logic [31:0] CAPTURE_WORD = 32'hDEAD_BEEF;

    // One sample of the three test pins.
    typedef struct packed {
        logic tck;
        logic tms;
        logic tdi;
    } pin_sample_t;

    // What happens at one detected test clock rising edge.
    typedef struct packed {
        logic       fire;
        tap_state_e dest;
        logic       tdi;
    } tap_step_t;

    function automatic tap_state_e tap_next(input tap_state_e cur, input logic sel);
        tap_state_e nxt;
        case (cur)
            ST_RESET:      nxt = sel ? ST_RESET     : ST_IDLE;
            ST_IDLE:       nxt = sel ? ST_DR_SELECT : ST_IDLE;
            ST_DR_SELECT:  nxt = sel ? ST_IR_SELECT : ST_DR_CAPTURE;
            ST_DR_CAPTURE: nxt = sel ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_SHIFT:   nxt = sel ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_EXIT1:   nxt = sel ? ST_DR_UPDATE : ST_DR_PAUSE;
            ST_DR_PAUSE:   nxt = sel ? ST_DR_EXIT2  : ST_DR_PAUSE;
            ST_DR_EXIT2:   nxt = sel ? ST_DR_UPDATE : ST_DR_SHIFT;
            ST_DR_UPDATE:  nxt = sel ? ST_DR_SELECT : ST_IDLE;
            ST_IR_SELECT:  nxt = sel ? ST_RESET     : ST_IR_CAPTURE;
            ST_IR_CAPTURE: nxt = sel ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_SHIFT:   nxt = sel ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_EXIT1:   nxt = sel ? ST_IR_UPDATE : ST_IR_PAUSE;
            ST_IR_PAUSE:   nxt = sel ? ST_IR_EXIT2  : ST_IR_PAUSE;
            ST_IR_EXIT2:   nxt = sel ? ST_IR_UPDATE : ST_IR_SHIFT;
            ST_IR_UPDATE:  nxt = sel ? ST_DR_SELECT : ST_IDLE;
            default:       nxt = ST_RESET;
        endcase
        return nxt;
    endfunction

    function automatic logic is_shift(input tap_state_e s);
        return (s == ST_DR_SHIFT) || (s == ST_IR_SHIFT);
    endfunction

endpackage

// File: rtl/scan_pin_sync.sv
module scan_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tck_pin,
    input  logic tms_pin,
    input  logic tdi_pin,
    output logic tck_rise,
    output logic tms_s,
    output logic tdi_s
);
    import scan_pkg::*;

    localparam int LAST = SYNC_STAGES - 1;

    pin_sample_t stage [SYNC_STAGES];
    logic        tck_prev;

    // All three pins travel the same chain so TMS/TDI line up with the edge.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= '0;
                else     stage[0] <= '{tck: tck_pin, tms: tms_pin, tdi: tdi_pin};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= stage[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tck_prev <= 1'b0;
        else     tck_prev <= stage[LAST].tck;
    end

    assign tck_rise = stage[LAST].tck & ~tck_prev;
    assign tms_s    = stage[LAST].tms;
    assign tdi_s    = stage[LAST].tdi;

    // R2: a detected edge lasts one system clock
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        tck_rise |=> !tck_rise);

endmodule

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tck_rise,
    input  logic                  tms_s,
    input  logic                  tdi_s,
    output scan_pkg::tap_state_e  state,
    output scan_pkg::tap_step_t   step
);
    import scan_pkg::*;

    tap_state_e state_q;
    tap_state_e dest;

    assign dest = tap_next(state_q, tms_s);

    always_ff @(posedge clk) begin
        if (rst)           state_q <= ST_RESET;
        else if (tck_rise) state_q <= dest;
    end

    assign state = state_q;
    assign step  = '{fire: tck_rise, dest: dest, tdi: tdi_s};

    // R1: reset lands in the reset state
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> state_q == ST_RESET);

    // R2: no edge, no move
    p_no_edge_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tck_rise |=> $stable(state_q));

    // R3: reset state holds on select high
    p_reset_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (tck_rise && tms_s && state_q == ST_RESET) |=> state_q == ST_RESET);

    // R3: idle holds on select low
    p_idle_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (tck_rise && !tms_s && state_q == ST_IDLE) |=> state_q == ST_IDLE);

    // R4: IR-select escapes to reset on select high
    p_ir_select_escape_r4: assert property (@(posedge clk) disable iff (rst)
        (tck_rise && tms_s && state_q == ST_IR_SELECT) |=> state_q == ST_RESET);

    // R3: shift states are only entered from capture, shift or exit2
    p_shift_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (tck_rise && dest == ST_DR_SHIFT) |->
            (state_q == ST_DR_CAPTURE || state_q == ST_DR_SHIFT || state_q == ST_DR_EXIT2));

endmodule

// File: rtl/scan_shift_reg.sv
module scan_shift_reg #(
    parameter int                   W          = 5,
    parameter logic [W-1:0]         RESET_VAL  = '0,
    parameter logic [W-1:0]         LOAD_VAL   = '0,
    parameter scan_pkg::tap_state_e LOAD_STATE = scan_pkg::ST_RESET,
    parameter scan_pkg::tap_state_e SHIFT_STATE = scan_pkg::ST_IR_SHIFT
) (
    input  logic                clk,
    input  logic                rst,
    input  scan_pkg::tap_step_t step,
    output logic                lsb
);
    logic [W-1:0] q;
    logic [W-1:0] shifted;
    logic         do_load;
    logic         do_shift;

    assign do_load  = step.fire && (step.dest == LOAD_STATE);
    assign do_shift = step.fire && (step.dest == SHIFT_STATE);

    if (W == 1) begin : g_single
        assign shifted = step.tdi;
    end else begin : g_multi
        assign shifted = {step.tdi, q[W-1:1]};

        // R7/R8: the body moves down by one place
        p_body_moves_r7: assert property (@(posedge clk) disable iff (rst)
            do_shift |=> q[W-2:0] == $past(q[W-1:1]));
    end

    always_ff @(posedge clk) begin
        if (rst)           q <= RESET_VAL;
        else if (do_load)  q <= LOAD_VAL;
        else if (do_shift) q <= shifted;
    end

    assign lsb = q[0];

    // R5 on the instruction instance, R6 on the data instance
    p_load_on_entry_r6: assert property (@(posedge clk) disable iff (rst)
        do_load |=> q == LOAD_VAL);

    // R7/R8: sampled data enters at the top bit
    p_top_bit_in_r8: assert property (@(posedge clk) disable iff (rst)
        do_shift |=> q[W-1] == $past(step.tdi));

    // R9: contents survive every other edge and idle cycle
    p_contents_kept_r9: assert property (@(posedge clk) disable iff (rst)
        !(do_load || do_shift) |=> $stable(q));

endmodule

// File: rtl/scan_tap.sv
module scan_tap #(
    parameter int IR_W        = 5,
    parameter int DR_W        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scan_clk_i,
    input  logic       scan_sel_i,
    input  logic       scan_in_i,
    output logic       scan_out_o,
    output logic [3:0] tap_state_o
);
    import scan_pkg::*;

    localparam logic [IR_W-1:0] IR_INIT = IR_W'(1);
    localparam logic [DR_W-1:0] DR_LOAD = DR_W'(CAPTURE_WORD);

    logic       tck_rise;
    logic       tms_s;
    logic       tdi_s;
    tap_state_e state;
    tap_step_t  step;
    logic       ir_lsb;
    logic       dr_lsb;
    logic       tdo_q;

    scan_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .tck_pin  (scan_clk_i),
        .tms_pin  (scan_sel_i),
        .tdi_pin  (scan_in_i),
        .tck_rise (tck_rise),
        .tms_s    (tms_s),
        .tdi_s    (tdi_s)
    );

    scan_tap_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tck_rise (tck_rise),
        .tms_s    (tms_s),
        .tdi_s    (tdi_s),
        .state    (state),
        .step     (step)
    );

    scan_shift_reg #(
        .W           (IR_W),
        .RESET_VAL   (IR_INIT),
        .LOAD_VAL    (IR_INIT),
        .LOAD_STATE  (ST_RESET),
        .SHIFT_STATE (ST_IR_SHIFT)
    ) u_ir (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .lsb  (ir_lsb)
    );

    scan_shift_reg #(
        .W           (DR_W),
        .RESET_VAL   ('0),
        .LOAD_VAL    (DR_LOAD),
        .LOAD_STATE  (ST_DR_CAPTURE),
        .SHIFT_STATE (ST_DR_SHIFT)
    ) u_dr (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .lsb  (dr_lsb)
    );

    // Output bit is taken from the register that shifts on this edge,
    // before that register moves.
    always_ff @(posedge clk) begin
        if (rst) begin
            tdo_q <= 1'b0;
        end else if (step.fire) begin
            if (step.dest == ST_DR_SHIFT)      tdo_q <= dr_lsb;
            else if (step.dest == ST_IR_SHIFT) tdo_q <= ir_lsb;
        end
    end

    assign scan_out_o  = tdo_q;
    assign tap_state_o = state;

    // R1: output low after reset
    p_out_low_after_reset_r1: assert property (@(posedge clk)
        rst |=> !scan_out_o);

    // R9: output only moves on an edge entering a shift state
    p_out_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !(tck_rise && is_shift(step.dest)) |=> $stable(scan_out_o));

    // R10: the controller sits in a shift state after any output-moving edge
    p_out_with_shift_r10: assert property (@(posedge clk) disable iff (rst)
        (tck_rise && is_shift(step.dest)) |=> is_shift(tap_state_e'(tap_state_o)));

endmodule

// File: tb/test_scan_tap.sv
module test_scan_tap;

    localparam int          CLK_PERIOD = 10;
    localparam int          IR_W       = 5;
    localparam int          DR_W       = 32;
    localparam logic [31:0] WORD       = 32'hDEAD_BEEF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_clk = 1'b0;
    logic       scan_sel = 1'b0;
    logic       scan_in  = 1'b0;
    logic       scan_out;
    logic [3:0] tap_state;

    int vectors     = 0;
    int miscompares = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scan_tap #(.IR_W(IR_W), .DR_W(DR_W), .SYNC_STAGES(2)) i_scan_tap (
        .clk         (clk),
        .rst         (rst),
        .scan_clk_i  (scan_clk),
        .scan_sel_i  (scan_sel),
        .scan_in_i   (scan_in),
        .scan_out_o  (scan_out),
        .tap_state_o (tap_state)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One full test clock period; the edge acts 3 system clocks after rising.
    task automatic pulse(input logic sel, input logic din);
        scan_sel = sel;
        scan_in  = din;
        scan_clk = 1'b1;
        repeat (4) @(negedge clk);
        scan_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic step_to(input logic sel, input logic [3:0] exp, input string tag);
        pulse(sel, 1'b0);
        check(tag, 32'(tap_state), 32'(exp));
    endtask

    task automatic to_reset;
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
    endtask

    task automatic to_idle;
        to_reset();
        pulse(1'b0, 1'b0);
    endtask

    task automatic test_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 state after reset", 32'(tap_state), 32'd0);
        check("R1 out after reset", 32'(scan_out), 32'd0);
    endtask

    task automatic test_walk;
        to_reset();
        step_to(1'b1, 4'd0,  "R3 reset holds");
        step_to(1'b0, 4'd1,  "R3 reset->idle");
        step_to(1'b0, 4'd1,  "R3 idle holds");
        step_to(1'b1, 4'd2,  "R3 idle->dr select");
        step_to(1'b0, 4'd3,  "R3 dr select->capture");
        step_to(1'b1, 4'd5,  "R3 dr capture->exit1");
        step_to(1'b0, 4'd6,  "R3 dr exit1->pause");
        step_to(1'b0, 4'd6,  "R3 dr pause holds");
        step_to(1'b1, 4'd7,  "R3 dr pause->exit2");
        step_to(1'b0, 4'd4,  "R3 dr exit2->shift");
        step_to(1'b0, 4'd4,  "R3 dr shift holds");
        step_to(1'b1, 4'd5,  "R3 dr shift->exit1");
        step_to(1'b1, 4'd8,  "R3 dr exit1->update");
        step_to(1'b0, 4'd1,  "R3 dr update->idle");
        step_to(1'b1, 4'd2,  "R3 idle->dr select");
        step_to(1'b0, 4'd3,  "R3 dr select->capture");
        step_to(1'b1, 4'd5,  "R3 dr capture->exit1");
        step_to(1'b0, 4'd6,  "R3 dr exit1->pause");
        step_to(1'b1, 4'd7,  "R3 dr pause->exit2");
        step_to(1'b1, 4'd8,  "R3 dr exit2->update");
        step_to(1'b1, 4'd2,  "R3 dr update->dr select");
        step_to(1'b1, 4'd9,  "R3 dr select->ir select");
        step_to(1'b0, 4'd10, "R3 ir select->capture");
        step_to(1'b0, 4'd11, "R3 ir capture->shift");
        step_to(1'b0, 4'd11, "R3 ir shift holds");
        step_to(1'b1, 4'd12, "R3 ir shift->exit1");
        step_to(1'b0, 4'd13, "R3 ir exit1->pause");
        step_to(1'b0, 4'd13, "R3 ir pause holds");
        step_to(1'b1, 4'd14, "R3 ir pause->exit2");
        step_to(1'b0, 4'd11, "R3 ir exit2->shift");
        step_to(1'b1, 4'd12, "R3 ir shift->exit1");
        step_to(1'b1, 4'd15, "R3 ir exit1->update");
        step_to(1'b1, 4'd2,  "R3 ir update->dr select");
        step_to(1'b1, 4'd9,  "R3 dr select->ir select");
        step_to(1'b0, 4'd10, "R3 ir select->capture");
        step_to(1'b1, 4'd12, "R3 ir capture->exit1");
        step_to(1'b1, 4'd15, "R3 ir exit1->update");
        step_to(1'b0, 4'd1,  "R3 ir update->idle");
        step_to(1'b1, 4'd2,  "R3 idle->dr select");
        step_to(1'b1, 4'd9,  "R3 dr select->ir select");
        step_to(1'b1, 4'd0,  "R3 ir select->reset");
    endtask

    task automatic test_no_edge;
        logic prev_out;
        to_idle();
        prev_out = scan_out;
        // Pins wiggle with the test clock held low.
        for (int i = 0; i < 20; i++) begin
            scan_sel = i[0];
            scan_in  = ~i[0];
            @(negedge clk);
        end
        check("R2 no edge keeps state", 32'(tap_state), 32'd1);
        check("R2 no edge keeps out", 32'(scan_out), 32'(prev_out));
        // One edge with select low, then select rises while the clock is high.
        scan_sel = 1'b0;
        scan_clk = 1'b1;
        repeat (4) @(negedge clk);
        scan_sel = 1'b1;
        repeat (12) @(negedge clk);
        scan_clk = 1'b0;
        repeat (8) @(negedge clk);
        check("R2 high-phase and falling edge ignored", 32'(tap_state), 32'd1);
    endtask

    task automatic test_force_reset;
        to_idle();
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        pulse(1'b0, 1'b0);
        check("R4 setup in dr shift", 32'(tap_state), 32'd4);
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
        check("R4 five highs from dr shift", 32'(tap_state), 32'd0);
        pulse(1'b0, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        pulse(1'b0, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        check("R4 setup in ir pause", 32'(tap_state), 32'd13);
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
        check("R4 five highs from ir pause", 32'(tap_state), 32'd0);
    endtask

    task automatic test_capture_readout;
        logic [31:0] got;
        to_idle();
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        check("R6 in dr capture", 32'(tap_state), 32'd3);
        got = '0;
        for (int i = 0; i < 32; i++) begin
            pulse(1'b0, 1'b0);
            got[i] = scan_out;
            if (i == 0) check("R10 first bit on entry edge", 32'(scan_out), 32'd1);
        end
        check("R6 captured word read LSB first", got, WORD);
        pulse(1'b1, 1'b0);
        check("R9 exit1 keeps last bit", 32'(scan_out), 32'(WORD[31]));
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        check("R9 update keeps last bit", 32'(scan_out), 32'(WORD[31]));
    endtask

    task automatic test_dr_shift_in;
        logic [31:0] a_word;
        logic [31:0] b_word;
        logic [31:0] first;
        logic [31:0] second;
        a_word = 32'h3C5A_9612;
        b_word = 32'hF00F_A5C3;
        to_idle();
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        first  = '0;
        second = '0;
        for (int i = 0; i < 64; i++) begin
            pulse(1'b0, (i < 32) ? a_word[i] : b_word[i - 32]);
            if (i < 32) first[i] = scan_out;
            else        second[i - 32] = scan_out;
        end
        check("R6 capture word ahead of new data", first, WORD);
        check("R7 shifted-in word comes back after 32 shifts", second, a_word);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
    endtask

    task automatic test_pause_resume;
        logic [31:0] got;
        to_idle();
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        got = '0;
        for (int i = 0; i < 10; i++) begin
            pulse(1'b0, 1'b0);
            got[i] = scan_out;
        end
        pulse(1'b1, 1'b0);
        check("R9 exit1 holds bit 9", 32'(scan_out), 32'(WORD[9]));
        pulse(1'b0, 1'b0);
        pulse(1'b0, 1'b0);
        check("R9 pause holds", 32'(tap_state), 32'd6);
        check("R9 pause keeps out", 32'(scan_out), 32'(WORD[9]));
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        got[10] = scan_out;
        check("R9 resumed shift gives bit 10", 32'(scan_out), 32'(WORD[10]));
        for (int i = 11; i < 32; i++) begin
            pulse(1'b0, 1'b0);
            got[i] = scan_out;
        end
        check("R9 split shift reads full word", got, WORD);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        pulse(1'b0, 1'b0);
        check("R6 recapture restores bit 0", 32'(scan_out), 32'(WORD[0]));
    endtask

    task automatic enter_ir_shift_from_reset;
        pulse(1'b0, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
    endtask

    task automatic test_ir;
        logic [IR_W-1:0] p_val;
        logic [IR_W-1:0] q_val;
        logic [IR_W-1:0] got_a;
        logic [IR_W-1:0] got_b;
        p_val = 5'b10110;
        q_val = 5'b01011;
        to_reset();
        enter_ir_shift_from_reset();
        check("R8 in ir capture", 32'(tap_state), 32'd10);
        for (int i = 0; i < 2 * IR_W; i++) begin
            pulse(1'b0, (i < IR_W) ? p_val[i] : q_val[i - IR_W]);
            if (i < IR_W) got_a[i] = scan_out;
            else          got_b[i - IR_W] = scan_out;
        end
        check("R5 ir reads 1 after reset state", 32'(got_a), 32'd1);
        check("R8 ir shifted-in value returns", 32'(got_b), 32'(p_val));
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        for (int i = 0; i < IR_W; i++) begin
            pulse(1'b0, 1'b0);
            got_a[i] = scan_out;
        end
        check("R9 ir kept across update and capture", 32'(got_a), 32'(q_val));
        pulse(1'b1, 1'b0);
        to_reset();
        enter_ir_shift_from_reset();
        for (int i = 0; i < IR_W; i++) begin
            pulse(1'b0, 1'b0);
            got_a[i] = scan_out;
        end
        check("R5 reset state reloads ir", 32'(got_a), 32'd1);
    endtask

    task automatic test_mid_reset;
        to_idle();
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        pulse(1'b0, 1'b0);
        check("R1 setup out high", 32'(scan_out), 32'd1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset state", 32'(tap_state), 32'd0);
        check("R1 mid-run reset out", 32'(scan_out), 32'd0);
    endtask

    initial begin
        test_reset();
        test_walk();
        test_no_edge();
        test_force_reset();
        test_capture_readout();
        test_dr_shift_in();
        test_pause_resume();
        test_ir();
        test_mid_reset();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule